// File: doc/BRIEF.md
# Burst Sample Capture Controller

This block records one burst of conversions from an external parallel 16-bit converter into an on-chip word store. It then hands the burst to a slower microcontroller over an 8-bit port. A start request from the idle state opens a capture burst. An internal rate divider then produces a sample tick every `DIV` system clocks. On each tick the block pulses the active-low conversion-start line and waits for the converter's busy line to drop. It then strobes the active-low converter read line and writes the result into the next free word.

Once `DEPTH` words are stored, the block stops converting and raises a full flag. The microcontroller then drains the store, one byte per access. It uses an asynchronous active-low read strobe and an asynchronous byte select, and both pass through two-flop synchronizers. The word pointer steps forward at the end of each high-byte access. When the last word has been drained, the block returns to idle and can accept a new start request. Capture and drain never overlap.

Top module: `adc_burst_capture`

## Requirements
- R1: A start request sampled while idle raises busy_o in the next cycle, and the first falling edge of adc_cnv_n_o comes exactly DIV clocks after the clock edge that sampled the start.
- R2: Within one burst, consecutive falling edges of adc_cnv_n_o are exactly DIV clocks apart, and adc_cnv_n_o is low only while busy_o is high.
- R3: Each conversion-start pulse keeps adc_cnv_n_o low for exactly CNV_LOW (default 2) clocks.
- R4: adc_rd_n_o falls only while adc_busy_i is low and stays low for exactly RD_LOW (default 3) clocks. The value on adc_data_i in the last low cycle is stored as the next word.
- R5: After DEPTH stored words, full_o is high, busy_o is low, and no further conversion-start or read pulses occur. Exactly DEPTH conversion-start pulses make up one burst.
- R6: While full, mcu_data_o shows the current word's bits 7:0 when mcu_hi_sel_i is 0 and bits 15:8 when mcu_hi_sel_i is 1. It follows the select after three clocks of latency.
- R7: The word pointer advances by one on each low-to-high transition of mcu_rd_n_i made with mcu_hi_sel_i at 1. A strobe made with the select at 0 leaves the pointer unchanged.
- R8: Words are drained in capture order starting from the first stored word. After the DEPTH-th pointer advance, full_o drops, the block is idle, and a new start opens a fresh burst at word 0.
- R9: A start request while busy_o or full_o is high is ignored. It changes neither the pulse timing nor the pulse count of the burst, and it does not change the stored data.
- R10: A synchronous reset (rst high at a clock edge) clears the counters, the pointer and the flags, returns the block to idle, and drives adc_cnv_n_o and adc_rd_n_o high.
- R11: busy_o and full_o are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin a capture burst |
| adc_busy_i | input | 1 | Converter busy, high while a conversion runs |
| adc_data_i | input | 16 | Converter parallel result |
| adc_cnv_n_o | output | 1 | Conversion start, active low |
| adc_rd_n_o | output | 1 | Converter read strobe, active low |
| mcu_rd_n_i | input | 1 | Microcontroller read strobe, active low, asynchronous |
| mcu_hi_sel_i | input | 1 | Byte select, 1 = upper byte, asynchronous |
| mcu_data_o | output | 8 | Selected byte of the current word |
| busy_o | output | 1 | High during the capture burst |
| full_o | output | 1 | High from the last capture until the last word is drained |

## Verification
The assertions assume that the converter raises its busy line while the conversion-start pulse is still low. They also assume it keeps busy high for fewer clocks than the sample period, so that no tick arrives while a conversion is in progress. The bench's converter model raises busy on the first clock it sees the start line low, holds it for four clocks, and runs with a sample period of twelve clocks. The microcontroller model changes the byte select only while its read strobe is high, and holds each level for at least four clocks. Both synchronized inputs therefore reach the logic as a consistent pair.

// File: rtl/adcbuf_pkg.sv
package adcbuf_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CONV,
    ST_BUSY,
    ST_READ,
    ST_FULL
  } cap_state_e;

  // Upper or lower byte of a word.
  function automatic logic [BYTE_W-1:0] byte_of(input logic [WORD_W-1:0] w,
                                                input logic hi);
    return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

  // True while the burst is in one of its capture states.
  function automatic logic is_capturing(input cap_state_e s);
    return (s == ST_WAIT) || (s == ST_CONV) || (s == ST_BUSY) || (s == ST_READ);
  endfunction

endpackage

// File: rtl/adcbuf_tick_gen.sv
module adcbuf_tick_gen #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int TW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [TW-1:0] cnt;

  assign tick = run && (cnt == TW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adcbuf_sync2.sv
module adcbuf_sync2 #(
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= {2{RST_VAL[b]}};
      else     sh <= {sh[0], d[b]};
    end
    assign q[b] = sh[1];
  end
endmodule

// File: rtl/adcbuf_store.sv
module adcbuf_store #(
  parameter int DEPTH = 2048,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/adc_burst_capture.sv
module adc_burst_capture
  import adcbuf_pkg::*;
#(
  parameter int DEPTH    = 2048,
  parameter int DIV      = 50,
  parameter int CNV_LOW  = 2,
  parameter int RD_LOW   = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic        adc_busy_i,
  input  logic [15:0] adc_data_i,
  output logic        adc_cnv_n_o,
  output logic        adc_rd_n_o,
  input  logic        mcu_rd_n_i,
  input  logic        mcu_hi_sel_i,
  output logic [7:0]  mcu_data_o,
  output logic        busy_o,
  output logic        full_o
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = AW + 1;
  localparam int PMAX = (CNV_LOW > RD_LOW) ? CNV_LOW : RD_LOW;
  localparam int PW   = $clog2(PMAX + 1);

  cap_state_e state, state_n;
  logic [PW-1:0] phase_cnt;
  logic [CW-1:0] wcount;
  logic [AW-1:0] rptr;
  logic          tick;
  logic          rd_s, sel_s, rd_s_d;
  logic [15:0]   rd_word;
  logic [7:0]    data_q;

  // Named internal events, used by the logic and by the checker.
  logic start_go, conv_done, wr_evt, last_wr, rd_rise, rd_evt, last_rd;

  assign busy_o      = is_capturing(state);
  assign full_o      = (state == ST_FULL);
  assign adc_cnv_n_o = (state != ST_CONV);
  assign adc_rd_n_o  = (state != ST_READ);
  assign mcu_data_o  = data_q;

  assign start_go  = (state == ST_IDLE) && start_i;
  assign conv_done = (state == ST_CONV) && (phase_cnt == PW'(CNV_LOW - 1));
  assign wr_evt    = (state == ST_READ) && (phase_cnt == PW'(RD_LOW - 1));
  assign last_wr   = wr_evt && (wcount == CW'(DEPTH - 1));
  assign rd_rise   = rd_s && !rd_s_d;
  assign rd_evt    = full_o && rd_rise && sel_s;
  assign last_rd   = rd_evt && (rptr == AW'(DEPTH - 1));

  adcbuf_tick_gen #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (busy_o),
    .tick (tick)
  );

  adcbuf_sync2 #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({mcu_rd_n_i, mcu_hi_sel_i}),
    .q   ({rd_s, sel_s})
  );

  adcbuf_store #(.DEPTH(DEPTH), .W(16)) u_store (
    .clk   (clk),
    .we    (wr_evt),
    .waddr (wcount[AW-1:0]),
    .wdata (adc_data_i),
    .raddr (rptr),
    .rdata (rd_word)
  );

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE: if (start_go)    state_n = ST_WAIT;
      ST_WAIT: if (tick)        state_n = ST_CONV;
      ST_CONV: if (conv_done)   state_n = ST_BUSY;
      ST_BUSY: if (!adc_busy_i) state_n = ST_READ;
      ST_READ: if (wr_evt)      state_n = last_wr ? ST_FULL : ST_WAIT;
      ST_FULL: if (last_rd)     state_n = ST_IDLE;
      default:                  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      phase_cnt <= '0;
      wcount    <= '0;
      rptr      <= '0;
      rd_s_d    <= 1'b1;
      data_q    <= '0;
    end else begin
      state     <= state_n;
      phase_cnt <= (state_n != state) ? '0 : phase_cnt + 1'b1;
      if (last_rd)     wcount <= '0;
      else if (wr_evt) wcount <= wcount + 1'b1;
      if (rd_evt)      rptr <= rptr + 1'b1;
      rd_s_d    <= rd_s;
      data_q    <= byte_of(rd_word, sel_s);
    end
  end
endmodule

// File: rtl/adcbuf_checks.sv
module adcbuf_checks #(
  parameter int DEPTH   = 2048,
  parameter int CNV_LOW = 2,
  parameter int RD_LOW  = 3,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = AW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          cnv_n,
  input logic          rd_n,
  input logic          adc_busy,
  input logic          busy_o,
  input logic          full_o,
  input logic          wr_evt,
  input logic          rd_evt,
  input logic [CW-1:0] wcount,
  input logic [AW-1:0] rptr
);
  logic [7:0] cnv_low_cnt, rd_low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnv_low_cnt <= '0;
      rd_low_cnt  <= '0;
    end else begin
      cnv_low_cnt <= cnv_n ? '0 : cnv_low_cnt + 1'b1;
      rd_low_cnt  <= rd_n  ? '0 : rd_low_cnt + 1'b1;
    end
  end

  a_r2_cnv_in_burst: assert property (@(posedge clk) disable iff (rst)
    !cnv_n |-> busy_o);

  a_r3_cnv_width: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(cnv_n)) |-> (cnv_low_cnt == 8'(CNV_LOW)));

  a_r4_rd_width: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(rd_n)) |-> (rd_low_cnt == 8'(RD_LOW)));

  a_r4_rd_after_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_n) |-> !adc_busy);

  a_r4_one_word: assert property (@(posedge clk) disable iff (rst)
    wr_evt |=> (wcount == $past(wcount) + 1'b1));

  a_r5_full_quiet: assert property (@(posedge clk) disable iff (rst)
    full_o |-> (cnv_n && rd_n));

  a_r7_ptr_step: assert property (@(posedge clk) disable iff (rst)
    rd_evt |=> (rptr == AW'($past(rptr) + 1'b1)));

  a_r8_drain_end: assert property (@(posedge clk) disable iff (rst)
    (rd_evt && rptr == AW'(DEPTH - 1)) |=> (!full_o && !busy_o && wcount == '0));

  a_r10_reset: assert property (@(posedge clk)
    rst |=> (cnv_n && rd_n && !busy_o && !full_o && wcount == '0 && rptr == '0));

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && full_o));
endmodule

bind adc_burst_capture adcbuf_checks #(
  .DEPTH(DEPTH), .CNV_LOW(CNV_LOW), .RD_LOW(RD_LOW)
) u_checks (
  .clk      (clk),
  .rst      (rst),
  .cnv_n    (adc_cnv_n_o),
  .rd_n     (adc_rd_n_o),
  .adc_busy (adc_busy_i),
  .busy_o   (busy_o),
  .full_o   (full_o),
  .wr_evt   (wr_evt),
  .rd_evt   (rd_evt),
  .wcount   (wcount),
  .rptr     (rptr)
);

// File: tb/test_adc_burst_capture.sv
module test_adc_burst_capture;
  localparam int DEPTH    = 8;
  localparam int DIV      = 12;
  localparam int CNV_LOW  = 2;
  localparam int RD_LOW   = 3;
  localparam int ADC_HOLD = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        adc_busy = 1'b0;
  logic [15:0] adc_data = 16'h0000;
  logic        mcu_rd_n = 1'b1;
  logic        mcu_hi_sel = 1'b0;
  logic        adc_cnv_n, adc_rd_n, busy_o, full_o;
  logic [7:0]  mcu_data;

  int     total = 0;
  int     bad = 0;
  longint cyc = 0;
  int     adc_k = 0;
  int     cnv_falls = 0;

  adc_burst_capture #(.DEPTH(DEPTH), .DIV(DIV), .CNV_LOW(CNV_LOW), .RD_LOW(RD_LOW))
  i_adc_burst_capture (
    .clk(clk), .rst(rst), .start_i(start_i),
    .adc_busy_i(adc_busy), .adc_data_i(adc_data),
    .adc_cnv_n_o(adc_cnv_n), .adc_rd_n_o(adc_rd_n),
    .mcu_rd_n_i(mcu_rd_n), .mcu_hi_sel_i(mcu_hi_sel),
    .mcu_data_o(mcu_data), .busy_o(busy_o), .full_o(full_o)
  );

  initial forever #10 clk = ~clk;
  initial forever begin @(posedge clk); cyc++; end

  function automatic logic [15:0] sample_val(input int k);
    return 16'((k * 4919 + 42371) ^ (k << 7));
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Converter model: busy for ADC_HOLD clocks after start seen low, then new data.
  initial forever begin
    @(negedge clk);
    if (!adc_busy && !adc_cnv_n && !rst) begin
      adc_busy = 1'b1;
      repeat (ADC_HOLD) @(negedge clk);
      adc_data = sample_val(adc_k);
      adc_k++;
      adc_busy = 1'b0;
    end
  end

  // Pulse timing monitor.
  initial begin
    logic   p_cnv = 1'b1, p_rd = 1'b1, p_busy = 1'b0, first = 1'b0;
    longint t_busy = 0, t_last = 0, t_cnv = 0, t_rd = 0;
    forever begin
      @(negedge clk);
      if (busy_o && !p_busy) begin t_busy = cyc; first = 1'b1; end
      if (!adc_cnv_n && p_cnv) begin
        cnv_falls++;
        if (first) chk(cyc - t_busy == DIV, "R1 first conversion delay", cyc - t_busy, DIV);
        else       chk(cyc - t_last == DIV, "R2 conversion spacing", cyc - t_last, DIV);
        chk(busy_o, "R2 conversion outside burst", busy_o, 1);
        first = 1'b0; t_last = cyc; t_cnv = cyc;
      end
      if (adc_cnv_n && !p_cnv && !rst)
        chk(cyc - t_cnv == CNV_LOW, "R3 conversion pulse width", cyc - t_cnv, CNV_LOW);
      if (!adc_rd_n && p_rd) begin
        chk(!adc_busy, "R4 read while busy", adc_busy, 0);
        t_rd = cyc;
      end
      if (adc_rd_n && !p_rd && !rst)
        chk(cyc - t_rd == RD_LOW, "R4 read pulse width", cyc - t_rd, RD_LOW);
      chk(!(busy_o && full_o), "R11 busy and full together", {busy_o, full_o}, 0);
      p_cnv = adc_cnv_n; p_rd = adc_rd_n; p_busy = busy_o;
    end
  end

  task automatic pulse_start();
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
  endtask

  task automatic mcu_access(input logic hi, output logic [7:0] got);
    mcu_hi_sel = hi;
    repeat (2) @(negedge clk);
    mcu_rd_n = 1'b0;
    repeat (5) @(negedge clk);
    got = mcu_data;
    mcu_rd_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic run_burst(output int base);
    int f0;
    int w;
    base = adc_k;
    f0 = cnv_falls;
    pulse_start();
    chk(busy_o, "R1 busy after start", busy_o, 1);
    repeat (DIV * 3) @(negedge clk);
    pulse_start();   // R9: start while capturing
    w = 0;
    while (!full_o && w < 5000) begin @(negedge clk); w++; end
    chk(full_o, "R5 full after burst", full_o, 1);
    chk(!busy_o, "R5 busy cleared when full", busy_o, 0);
    chk(cnv_falls - f0 == DEPTH, "R5 pulses per burst", cnv_falls - f0, DEPTH);
    pulse_start();   // R9: start while full
    repeat (DIV * 3) @(negedge clk);
    chk(cnv_falls - f0 == DEPTH, "R9 start while full ignored", cnv_falls - f0, DEPTH);
    chk(full_o && !busy_o, "R9 still full", {busy_o, full_o}, 1);
  endtask

  task automatic drain(input int base);
    logic [7:0]  got;
    logic [15:0] ev;
    for (int i = 0; i < DEPTH; i++) begin
      ev = sample_val(base + i);
      mcu_access(1'b0, got);
      chk(got == ev[7:0], "R6 low byte", got, ev[7:0]);
      if (i == 0 || i == DEPTH - 1) begin
        mcu_access(1'b0, got);
        chk(got == ev[7:0], "R7 low strobe holds word", got, ev[7:0]);
        mcu_hi_sel = 1'b1;
        repeat (5) @(negedge clk);
        chk(mcu_data == ev[15:8], "R7 select without strobe", mcu_data, ev[15:8]);
      end
      chk(full_o, "R8 full during drain", full_o, 1);
      mcu_access(1'b1, got);
      chk(got == ev[15:8], "R6 high byte", got, ev[15:8]);
    end
    chk(!full_o && !busy_o, "R8 idle after drain", {busy_o, full_o}, 0);
  endtask

  initial begin
    int base;
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk(adc_cnv_n && adc_rd_n, "R10 lines high in reset", {adc_cnv_n, adc_rd_n}, 3);
    chk(!busy_o && !full_o, "R10 flags clear in reset", {busy_o, full_o}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(adc_cnv_n && !busy_o, "R10 idle without start", {adc_cnv_n, busy_o}, 2);

    run_burst(base);
    drain(base);

    // New burst, interrupted by reset after its first stored word.
    pulse_start();
    chk(busy_o, "R8 new burst after drain", busy_o, 1);
    @(posedge adc_rd_n);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(adc_cnv_n && adc_rd_n, "R10 lines high after reset", {adc_cnv_n, adc_rd_n}, 3);
    chk(!busy_o && !full_o, "R10 flags clear after reset", {busy_o, full_o}, 0);
    while (adc_busy) @(negedge clk);
    repeat (DIV * 2) @(negedge clk);
    chk(adc_cnv_n && !busy_o, "R10 stays idle", {adc_cnv_n, busy_o}, 2);

    run_burst(base);
    drain(base);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule